// File: doc/BRIEF.md
# Bus-Master DMA Channel Control and Status Registers

This block is the host-side register file of one bus-master disk DMA channel. Software reaches it through a byte-wide register port with a combinational read path. The port holds a command byte (run and direction), a status byte, and a descriptor table pointer one byte wide per address. The block takes three event inputs. Two come from the DMA engine: end of table and error. The third is the drive's interrupt line. From these it keeps the run, error and interrupt flags.

Two decoders read the status byte directly. The first gives the completion code that software would compute when a transfer ends. The second gives the action to take when the software DMA watchdog expires: keep waiting, report an error, or reset the bus. Descriptor fetching and drive signalling live elsewhere. No data passes through this block, so every pin is plain control or status and no valid/ready handshake is used.

The register map is: address 0 is the command byte, address 1 is the status byte, addresses 2 and 3 are unused, and addresses 4 to 7 hold the pointer, least significant byte first.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, every register reads 0, `dma_go`, `dma_dir` and `irq_pend` are 0, `tbl_ptr` is 0, `end_code` is 0x10 and `tmo_action` is 0 (bus reset).
- R2: Writing address 0 with bit 0 = 1 while the stored run bit is 0 sets `dma_go` on the next cycle. Writing address 0 with bit 0 = 0 clears the run bit and `dma_go`.
- R3: Command bit 3 is the direction, where 1 means device to memory, and it drives `dma_dir`. It is updated only by a command write made while the stored run bit is 0. A command read returns the run bit in bit 0, direction in bit 3, and zeros elsewhere.
- R4: `eng_done` or `eng_err` clears `dma_go`. If a run-bit 0-to-1 write happens in the same cycle, that write wins and `dma_go` is 1.
- R5: Status bit 1 (error) sets when `eng_err` is high. Writing status with bit 1 = 1 clears it. If a set and a clear happen in the same cycle, the set wins.
- R6: Status bit 2 (interrupt) sets on a rising edge of `drv_irq` only; a level held high does not set it again. Writing status with bit 2 = 1 clears it, and a set in the same cycle wins. `irq_pend` equals this bit.
- R7: The status byte reads as: bit 0 run, bit 1 error, bit 2 interrupt, bits 3 and 4 software scratch flags, bits 5 and 6 capability flags for drive 0 and drive 1, bit 7 zero. Bits 6:3 take the written value. Writing 0 to bits 2:0 has no effect.
- R8: Pointer bytes at addresses 4 to 7 are little-endian and drive `tbl_ptr`. Pointer bits 1:0 always read as 0. Addresses 2 and 3 read as 0 and writes to them change nothing.
- R9: `end_code` is 0 when status bits 2:0 equal 100b. Otherwise it is the status byte ORed with 0x10.
- R10: `tmo_action` encodes 1 = keep waiting, 2 = error, 0 = bus reset. The checks run in this priority order: status bits 4 and 3 both set gives 1; else bit 1 gives 2; else bit 0 or bit 2 gives 1; else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe for the addressed byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed byte, combinational |
| eng_done | input | 1 | Engine reached end of descriptor table |
| eng_err | input | 1 | Engine reports a transfer error |
| drv_irq | input | 1 | Drive interrupt line |
| dma_go | output | 1 | Run flag (status bit 0) |
| dma_dir | output | 1 | Direction, 1 = device to memory |
| tbl_ptr | output | 8*PTR_BYTES | Descriptor table pointer |
| irq_pend | output | 1 | Interrupt pending (status bit 2) |
| end_code | output | 8 | Completion code |
| tmo_action | output | 2 | Watchdog-expiry action |

## Verification
The bench uses the default parameters: a 3-bit address and a 4-byte pointer. With these, every address the port can form is exercised, including the two unused holes and the masked low pointer byte. At this size every status byte that the stimulus produces can be decoded by both the completion and the watchdog rules, and each decoder is compared every cycle. The stimulus covers the same-cycle collisions: run write against engine stop, and event set against write-1-to-clear.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [1:0] {
    TMO_RESET = 2'd0,
    TMO_WAIT  = 2'd1,
    TMO_FAIL  = 2'd2
  } tmo_act_e;

  localparam int REG_CMD  = 0;
  localparam int REG_STS  = 1;
  localparam int PTR_BASE = 4;
endpackage

// File: rtl/bmdma_cmd.sv
module bmdma_cmd (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_cmd,
  input  logic run_bit,
  input  logic dir_bit,
  input  logic eng_stop,
  output logic run_q,
  output logic dir_q,
  output logic act_q
);
  logic run_rise;
  assign run_rise = wr_cmd & run_bit & ~run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      if (wr_cmd) begin
        run_q <= run_bit;
        if (!run_q) dir_q <= dir_bit;
      end
      // a fresh start outranks any stop source in the same cycle
      if (run_rise) act_q <= 1'b1;
      else if ((wr_cmd & ~run_bit) | eng_stop) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bmdma_sts.sv
module bmdma_sts (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sts,
  input  logic [6:1] wbits,
  input  logic       eng_err,
  input  logic       drv_irq,
  input  logic       act,
  output logic [7:0] sts
);
  logic       err_q, irq_q, irq_d;
  logic [3:0] flags_q;
  logic       irq_rise;

  assign irq_rise = drv_irq & ~irq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      irq_d   <= 1'b0;
      flags_q <= '0;
    end else begin
      irq_d <= drv_irq;
      if (eng_err) err_q <= 1'b1;
      else if (wr_sts && wbits[1]) err_q <= 1'b0;
      if (irq_rise) irq_q <= 1'b1;
      else if (wr_sts && wbits[2]) irq_q <= 1'b0;
      if (wr_sts) flags_q <= wbits[6:3];
    end
  end

  assign sts = {1'b0, flags_q, irq_q, err_q, act};
endmodule

// File: rtl/bmdma_ptr.sv
module bmdma_ptr #(
  parameter int ADDR_W    = 3,
  parameter int PTR_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [8*PTR_BYTES-1:0] ptr
);
  import bmdma_pkg::*;

  for (genvar b = 0; b < PTR_BYTES; b++) begin : g_byte
    logic hit;
    logic [7:0] q;
    assign hit = wr && (addr == ADDR_W'(PTR_BASE + b));
    if (b == 0) begin : g_low
      // table must be dword aligned: two lowest bits are tied off
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (hit) q <= {wdata[7:2], 2'b00};
      end
    end else begin : g_high
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (hit) q <= wdata;
      end
    end
    assign ptr[8*b +: 8] = q;
  end
endmodule

// File: rtl/bmdma_eval.sv
module bmdma_eval (
  input  logic                  [7:0] sts,
  output logic                  [7:0] end_code,
  output bmdma_pkg::tmo_act_e         tmo_action
);
  import bmdma_pkg::*;

  always_comb begin
    end_code = (sts[2:0] == 3'b100) ? 8'h00 : (sts | 8'h10);
    if (sts[4] && sts[3])      tmo_action = TMO_WAIT;
    else if (sts[1])           tmo_action = TMO_FAIL;
    else if (sts[0] || sts[2]) tmo_action = TMO_WAIT;
    else                       tmo_action = TMO_RESET;
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int ADDR_W    = 3,
  parameter int PTR_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_wr,
  input  logic [7:0]             reg_wdata,
  output logic [7:0]             reg_rdata,
  input  logic                   eng_done,
  input  logic                   eng_err,
  input  logic                   drv_irq,
  output logic                   dma_go,
  output logic                   dma_dir,
  output logic [8*PTR_BYTES-1:0] tbl_ptr,
  output logic                   irq_pend,
  output logic [7:0]             end_code,
  output logic [1:0]             tmo_action
);
  import bmdma_pkg::*;

  logic     wr_cmd, wr_sts, run_q, act_q;
  logic [7:0] sts;
  tmo_act_e act_e;

  assign wr_cmd = reg_wr && (reg_addr == ADDR_W'(REG_CMD));
  assign wr_sts = reg_wr && (reg_addr == ADDR_W'(REG_STS));

  bmdma_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd),
    .run_bit(reg_wdata[0]), .dir_bit(reg_wdata[3]),
    .eng_stop(eng_done | eng_err),
    .run_q(run_q), .dir_q(dma_dir), .act_q(act_q)
  );

  bmdma_sts u_sts (
    .clk(clk), .rst_n(rst_n), .wr_sts(wr_sts), .wbits(reg_wdata[6:1]),
    .eng_err(eng_err), .drv_irq(drv_irq), .act(act_q), .sts(sts)
  );

  bmdma_ptr #(.ADDR_W(ADDR_W), .PTR_BYTES(PTR_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .ptr(tbl_ptr)
  );

  bmdma_eval u_eval (.sts(sts), .end_code(end_code), .tmo_action(act_e));

  assign tmo_action = act_e;
  assign dma_go     = act_q;
  assign irq_pend   = sts[2];

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == ADDR_W'(REG_CMD)) reg_rdata = {4'b0000, dma_dir, 2'b00, run_q};
    else if (reg_addr == ADDR_W'(REG_STS)) reg_rdata = sts;
    for (int b = 0; b < PTR_BYTES; b++)
      if (reg_addr == ADDR_W'(PTR_BASE + b)) reg_rdata = tbl_ptr[8*b +: 8];
  end
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              wd0,
  input logic              eng_done,
  input logic              eng_err,
  input logic              drv_irq,
  input logic              run_q,
  input logic              dma_go,
  input logic              dma_dir,
  input logic              irq_pend,
  input logic [7:0]        end_code,
  input logic [1:0]        tmo_action
);
  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0 && wd0 && !run_q) |=> dma_go);
  // R4
  stop_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((eng_done || eng_err) && !(reg_wr && reg_addr == '0)) |=> !dma_go);
  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(dma_dir));
  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_irq) |=> irq_pend);
  // R5
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> (end_code != 8'h00));
  // R10
  tmo_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_action != 2'd3);
endmodule

bind bmdma_regs bmdma_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .wd0(reg_wdata[0]), .eng_done(eng_done), .eng_err(eng_err),
  .drv_irq(drv_irq), .run_q(run_q), .dma_go(dma_go), .dma_dir(dma_dir),
  .irq_pend(irq_pend), .end_code(end_code), .tmo_action(tmo_action)
);

// File: tb/sim_bmdma_regs.sv
module sim_bmdma_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, eng_done = 1'b0, eng_err = 1'b0, drv_irq = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata, end_code;
  logic dma_go, dma_dir, irq_pend;
  logic [31:0] tbl_ptr;
  logic [1:0] tmo_action;

  int n_cmp = 0, n_bad = 0;

  // behavioural model
  bit m_run, m_dir, m_act, m_err, m_irq, m_irqd;
  bit [3:0] m_flags;
  bit [7:0] m_ptr [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  bmdma_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_done(eng_done),
    .eng_err(eng_err), .drv_irq(drv_irq), .dma_go(dma_go), .dma_dir(dma_dir),
    .tbl_ptr(tbl_ptr), .irq_pend(irq_pend), .end_code(end_code),
    .tmo_action(tmo_action)
  );

  function automatic bit [7:0] m_sts();
    return {1'b0, m_flags, m_irq, m_err, m_act};
  endfunction

  function automatic bit [7:0] m_read(int a);
    if (a == 0) return {4'b0, m_dir, 2'b0, m_run};
    if (a == 1) return m_sts();
    if (a >= 4) return m_ptr[a-4];
    return 8'h00;
  endfunction

  function automatic bit [7:0] m_code();
    bit [7:0] s = m_sts();
    return (s[2:0] == 3'b100) ? 8'h00 : (s | 8'h10);
  endfunction

  function automatic bit [1:0] m_tmo();
    bit [7:0] s = m_sts();
    if (s[4] && s[3]) return 2'd1;
    if (s[1]) return 2'd2;
    if (s[0] || s[2]) return 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %h expected %h", req, $time, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk({tag, " R2 dma_go"}, 32'(dma_go), 32'(m_act));
    chk({tag, " R3 dma_dir"}, 32'(dma_dir), 32'(m_dir));
    chk({tag, " R8 tbl_ptr"}, tbl_ptr, {m_ptr[3], m_ptr[2], m_ptr[1], m_ptr[0]});
    chk({tag, " R6 irq_pend"}, 32'(irq_pend), 32'(m_irq));
    chk({tag, " R9 end_code"}, 32'(end_code), 32'(m_code()));
    chk({tag, " R10 tmo_action"}, 32'(tmo_action), 32'(m_tmo()));
    chk({tag, " R7 rdata"}, 32'(reg_rdata), 32'(m_read(int'(reg_addr))));
  endtask

  task automatic step(input bit wr, input int a, input bit [7:0] wd,
                      input bit done, input bit err, input bit irq);
    bit rise, cmdw, stsw;
    reg_wr = wr; reg_addr = 3'(a); reg_wdata = wd;
    eng_done = done; eng_err = err; drv_irq = irq;
    @(posedge clk);
    cmdw = wr && a == 0;
    stsw = wr && a == 1;
    rise = cmdw && wd[0] && !m_run;
    if (rise) m_act = 1;
    else if ((cmdw && !wd[0]) || done || err) m_act = 0;
    if (cmdw) begin
      if (!m_run) m_dir = wd[3];
      m_run = wd[0];
    end
    if (err) m_err = 1; else if (stsw && wd[1]) m_err = 0;
    if (irq && !m_irqd) m_irq = 1; else if (stsw && wd[2]) m_irq = 0;
    m_irqd = irq;
    if (stsw) m_flags = wd[6:3];
    if (wr && a >= 4) m_ptr[a-4] = (a == 4) ? (wd & 8'hFC) : wd;
    #1;
    compare_all("step");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    foreach (m_ptr[i]) m_ptr[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1 end_code", 32'(end_code), 32'h10);
    chk("R1 tmo_action", 32'(tmo_action), 32'd0);
    compare_all("R1");
    rst_n = 1'b1;
    // R8: pointer bytes, low bits masked, holes ignored
    step(1, 4, 8'h13, 0, 0, 0);
    step(1, 5, 8'h57, 0, 0, 0);
    step(1, 6, 8'h9B, 0, 0, 0);
    step(1, 7, 8'hDF, 0, 0, 0);
    chk("R8 ptr value", tbl_ptr, 32'hDF9B5710);
    step(1, 2, 8'hFF, 0, 0, 0);
    step(1, 3, 8'hFF, 0, 0, 0);
    step(0, 2, 8'h00, 0, 0, 0);
    step(0, 4, 8'h00, 0, 0, 0);
    // R3/R2: direction then start, direction locked while running
    step(1, 0, 8'h08, 0, 0, 0);
    step(1, 0, 8'h09, 0, 0, 0);
    chk("R2 go after start", 32'(dma_go), 32'd1);
    step(1, 0, 8'h01, 0, 0, 0);
    chk("R3 dir locked", 32'(dma_dir), 32'd1);
    step(0, 0, 8'h00, 0, 0, 0);
    // R4: engine end of table
    step(0, 1, 8'h00, 1, 0, 0);
    chk("R4 done stops", 32'(dma_go), 32'd0);
    // R6: interrupt rise, held level, clear
    step(0, 1, 8'h00, 0, 0, 1);
    chk("R9 clean end", 32'(end_code), 32'h00);
    step(0, 1, 8'h00, 0, 0, 1);
    step(1, 1, 8'h04, 0, 0, 1);
    chk("R6 held level no reset", 32'(irq_pend), 32'd0);
    step(0, 1, 8'h00, 0, 0, 0);
    step(1, 1, 8'h04, 0, 0, 1);
    chk("R6 set beats clear", 32'(irq_pend), 32'd1);
    step(1, 1, 8'h00, 0, 0, 0);
    step(1, 1, 8'h04, 0, 0, 0);
    // R5: error path and collision
    step(1, 0, 8'h00, 0, 0, 0);
    step(1, 0, 8'h01, 0, 0, 0);
    step(0, 1, 8'h00, 0, 1, 0);
    chk("R10 error fail", 32'(tmo_action), 32'd2);
    step(1, 1, 8'h02, 0, 1, 0);
    chk("R5 set beats clear", 32'(reg_rdata), 32'h02);
    // R10: scratch bits 4:3 override error
    step(1, 1, 8'h18, 0, 0, 0);
    chk("R10 early wait", 32'(tmo_action), 32'd1);
    step(1, 1, 8'h62, 0, 0, 0);
    chk("R7 caps readback", 32'(reg_rdata), 32'h60);
    // R4: start write beats engine stop
    step(1, 0, 8'h00, 0, 0, 0);
    step(1, 0, 8'h01, 1, 0, 0);
    chk("R4 start wins", 32'(dma_go), 32'd1);
    step(0, 1, 8'h00, 0, 0, 0);
    chk("R10 running wait", 32'(tmo_action), 32'd1);
    step(1, 0, 8'h00, 0, 0, 0);
    chk("R2 stop write", 32'(dma_go), 32'd0);
    step(0, 1, 8'h00, 0, 0, 0);
    chk("R10 idle reset", 32'(tmo_action), 32'd0);
    chk("R9 fail code", 32'(end_code), 32'h70);
    // R3: direction change allowed while stopped
    step(1, 0, 8'h00, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0);
    chk("R3 dir cleared", 32'(dma_dir), 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule